// File: doc/BRIEF.md
# Integer Carry and Overflow Flag Unit

This block sits next to an integer ALU and turns an executed operation into the fixed-point exception flags. It receives the operands the operation consumed, an optional immediate, the result the ALU produced, and a set of per-instruction controls. From these it keeps registered copies of the carry flags (full width and lower half), the overflow flags (full width and lower half), a sticky summary overflow, and a four-bit condition field that describes the sign of the result.

Each flag group has its own enable, so one instruction can update carry, overflow and the condition field independently. Carry is inferred from the result itself: an operand that is unsigned-greater than the result implies a wrap. The lower-half carry of an add uses a parity rule on the half boundary bit instead. A subtract-style operation asks for the first operand to be inverted before evaluation. A divide supplies its own overflow verdict. An operation that produces its own carry can mask the carry writes.

Operation data arrives as a single-cycle strobe. The block never applies back-pressure and takes one operation in every cycle the strobe is high. Without the strobe, no register changes.

Top module: `cov_flag_unit`

## Requirements
- R1: After reset, all flag outputs and the condition field are 0.
- R2: In a cycle where `in_valid` is low, no output changes on the next clock edge. The same holds for each flag group whose enable is low.
- R3: When `invert_a` is 1, the bitwise complement of `op_a` replaces `op_a` in every flag rule.
- R4: When `imm_present` is 1, `imm` is the second operand and `op_b` is ignored. A second operand exists when `op_b_present` or `imm_present` is 1.
- R5: With `carry_en`, `ca` becomes 1 exactly when the first operand, or the second operand if it exists, is unsigned-greater than the full `result`.
- R6: With `carry_en` and `is_add`, `ca32` becomes bit 32 of `result` XOR bit 32 of the first operand XOR bit 32 of the second operand (0 if there is no second operand). Without `is_add`, `ca32` is 1 when the low 32 bits of either operand are unsigned-greater than the low 32 bits of `result`.
- R7: With `ovf_en` and two operands, `ov` is 1 when both operands have the same top bit and the top bit of `result` differs from it. `ov32` applies the same rule to bit 31.
- R8: With `ovf_en` and `div_ovf_present`, both `ov` and `ov32` take the value of `div_ovf`, whatever the operands are.
- R9: With `ovf_en`, no `div_ovf_present` and fewer than two operands, `ov`, `ov32` and `so` keep their values.
- R10: On every overflow update (R7 or R8), `so` becomes the old `so` OR the new `ov`. `so` never returns to 0 except through reset.
- R11: `carry_skip[0]` = 1 blocks the `ca` write and `carry_skip[1]` = 1 blocks the `ca32` write.
- R12: With `record_en`, `cr0` takes the value {negative, positive, zero, so}, with bit 3 = negative and bit 0 = so. The sign comes from `result` read as a signed value. `so` is the value after this operation's overflow update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One operation is presented this cycle |
| op_a | input | XLEN | First operand |
| op_b | input | XLEN | Second register operand |
| op_b_present | input | 1 | `op_b` is a real operand |
| imm | input | XLEN | Immediate operand |
| imm_present | input | 1 | Immediate replaces the second operand |
| result | input | XLEN | ALU result of the operation |
| is_add | input | 1 | Operation is an add (selects the half-carry parity rule) |
| invert_a | input | 1 | Complement the first operand before evaluation |
| carry_en | input | 1 | Update the carry flags |
| ovf_en | input | 1 | Update the overflow flags and summary overflow |
| record_en | input | 1 | Update the condition field |
| carry_skip | input | 2 | Bit 0 masks the `ca` write, bit 1 masks the `ca32` write |
| div_ovf_present | input | 1 | Divide-overflow verdict is supplied |
| div_ovf | input | 1 | Divide-overflow verdict |
| ca | output | 1 | Full-width carry |
| ca32 | output | 1 | Lower-half carry |
| ov | output | 1 | Full-width overflow |
| ov32 | output | 1 | Lower-half overflow |
| so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | Condition field {negative, positive, zero, so} |

## Verification
The bench builds the unit with its default width of 64 bits, so the half lane is 32 bits wide. This puts the half-boundary parity bit at 32 and the half sign bit at 31, exactly where the directed cases place carries and sign crossings. Random operands and results, together with random enables, masks and operand-presence bits, mix both carry rules and both overflow sources. Directed cases cover the all-ones wrap, the zero and negative results, and the single-operand overflow hold.

// File: rtl/cov_pkg.sv
package cov_pkg;
  // condition field bit positions (decoded by downstream branch logic)
  localparam int CR_NEG = 3;
  localparam int CR_POS = 2;
  localparam int CR_ZER = 1;
  localparam int CR_SUM = 0;
  localparam int CR_W   = 4;

  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
    logic so;
  } cov_flags_t;
endpackage

// File: rtl/cov_carry.sv
module cov_carry #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         has_b,
  input  logic [W-1:0] res,
  input  logic         is_add,
  output logic         ca,
  output logic         ca32
);
  localparam int H = W / 2;

  logic a_gt, b_gt, a_gt_h, b_gt_h, par_h;

  always_comb begin
    a_gt   = a > res;
    b_gt   = has_b && (b > res);
    a_gt_h = a[H-1:0] > res[H-1:0];
    b_gt_h = has_b && (b[H-1:0] > res[H-1:0]);
    par_h  = res[H] ^ a[H] ^ (has_b & b[H]);
    ca     = a_gt | b_gt;
    ca32   = is_add ? par_h : (a_gt_h | b_gt_h);
  end
endmodule

// File: rtl/cov_sign_ovf.sv
module cov_sign_ovf #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] res,
  output logic         ovf
);
  logic same_in;
  always_comb begin
    same_in = a[W-1] ~^ b[W-1];
    ovf     = same_in & (res[W-1] ^ a[W-1]);
  end
endmodule

// File: rtl/cov_cr0.sv
module cov_cr0
  import cov_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]    res,
  input  logic            so_now,
  output logic [CR_W-1:0] cr
);
  logic is_zero, is_neg;
  always_comb begin
    is_zero     = (res == '0);
    is_neg      = res[W-1];
    cr          = '0;
    cr[CR_NEG]  = is_neg;
    cr[CR_POS]  = ~is_neg & ~is_zero;
    cr[CR_ZER]  = is_zero;
    cr[CR_SUM]  = so_now;
  end
endmodule

// File: rtl/cov_flag_unit.sv
module cov_flag_unit
  import cov_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            op_b_present,
  input  logic [XLEN-1:0] imm,
  input  logic            imm_present,
  input  logic [XLEN-1:0] result,
  input  logic            is_add,
  input  logic            invert_a,
  input  logic            carry_en,
  input  logic            ovf_en,
  input  logic            record_en,
  input  logic [1:0]      carry_skip,
  input  logic            div_ovf_present,
  input  logic            div_ovf,
  output logic            ca,
  output logic            ca32,
  output logic            ov,
  output logic            ov32,
  output logic            so,
  output logic [3:0]      cr0
);
  localparam int NLANE = 2;

  logic [XLEN-1:0] a_eff, b_eff;
  logic            has_b;
  logic            ca_n, ca32_n;
  logic [NLANE-1:0] lane_ovf;
  logic            ov_n, ov32_n, ov_wr, so_n;
  logic [CR_W-1:0] cr_n;
  cov_flags_t      fl_q, fl_d;
  logic [CR_W-1:0] cr_q;

  always_comb begin
    a_eff = invert_a ? ~op_a : op_a;
    b_eff = imm_present ? imm : op_b;
    has_b = op_b_present | imm_present;
  end

  cov_carry #(.W(XLEN)) u_carry (
    .a(a_eff), .b(b_eff), .has_b(has_b), .res(result),
    .is_add(is_add), .ca(ca_n), .ca32(ca32_n)
  );

  // lane 0 is full width, lane 1 the lower half
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = XLEN >> g;
    cov_sign_ovf #(.W(LW)) u_ovf (
      .a(a_eff[LW-1:0]), .b(b_eff[LW-1:0]), .res(result[LW-1:0]),
      .ovf(lane_ovf[g])
    );
  end

  always_comb begin
    ov_wr  = ovf_en & (div_ovf_present | has_b);
    ov_n   = div_ovf_present ? div_ovf : lane_ovf[0];
    ov32_n = div_ovf_present ? div_ovf : lane_ovf[1];
    so_n   = ov_wr ? (fl_q.so | ov_n) : fl_q.so;
  end

  cov_cr0 #(.W(XLEN)) u_cr0 (.res(result), .so_now(so_n), .cr(cr_n));

  always_comb begin
    fl_d = fl_q;
    if (carry_en && !carry_skip[0]) fl_d.ca   = ca_n;
    if (carry_en && !carry_skip[1]) fl_d.ca32 = ca32_n;
    if (ov_wr) begin
      fl_d.ov   = ov_n;
      fl_d.ov32 = ov32_n;
    end
    fl_d.so = so_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_q <= '0;
      cr_q <= '0;
    end else if (in_valid) begin
      fl_q <= fl_d;
      if (record_en) cr_q <= cr_n;
    end
  end

  assign ca   = fl_q.ca;
  assign ca32 = fl_q.ca32;
  assign ov   = fl_q.ov;
  assign ov32 = fl_q.ov32;
  assign so   = fl_q.so;
  assign cr0  = cr_q;
endmodule

// File: rtl/cov_flag_unit_chk.sv
module cov_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       op_b_present,
  input logic       imm_present,
  input logic       ovf_en,
  input logic       record_en,
  input logic [1:0] carry_skip,
  input logic       div_ovf_present,
  input logic       div_ovf,
  input logic       ca,
  input logic       ca32,
  input logic       ov,
  input logic       ov32,
  input logic       so,
  input logic [3:0] cr0
);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({ca, ca32, ov, ov32, so, cr0}));

  assert_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf_en && div_ovf_present) |=> (ov == $past(div_ovf)) && (ov32 == $past(div_ovf)));

  assert_lone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf_en && !div_ovf_present && !op_b_present && !imm_present)
      |=> $stable(ov) && $stable(ov32) && $stable(so));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    so |=> so);

  assert_skip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carry_skip[0]) |=> $stable(ca));

  assert_cr0_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && record_en) |=> ($countones(cr0[3:1]) == 1) && (cr0[0] == so));
endmodule

bind cov_flag_unit cov_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .op_b_present(op_b_present), .imm_present(imm_present),
  .ovf_en(ovf_en), .record_en(record_en), .carry_skip(carry_skip),
  .div_ovf_present(div_ovf_present), .div_ovf(div_ovf),
  .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so), .cr0(cr0)
);

// File: tb/test_cov_flag_unit.sv
module test_cov_flag_unit;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [XLEN-1:0] op_a = '0, op_b = '0, imm = '0, result = '0;
  logic op_b_present = 1'b0, imm_present = 1'b0, is_add = 1'b0, invert_a = 1'b0;
  logic carry_en = 1'b0, ovf_en = 1'b0, record_en = 1'b0;
  logic [1:0] carry_skip = 2'b00;
  logic div_ovf_present = 1'b0, div_ovf = 1'b0;
  logic ca, ca32, ov, ov32, so;
  logic [3:0] cr0;

  int n_chk = 0, n_bad = 0;
  logic m_ca = 0, m_ca32 = 0, m_ov = 0, m_ov32 = 0, m_so = 0;
  logic [3:0] m_cr = 0;

  always #2 clk = ~clk;

  cov_flag_unit #(.XLEN(XLEN)) i_cov_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_b_present(op_b_present), .imm(imm), .imm_present(imm_present),
    .result(result), .is_add(is_add), .invert_a(invert_a), .carry_en(carry_en),
    .ovf_en(ovf_en), .record_en(record_en), .carry_skip(carry_skip),
    .div_ovf_present(div_ovf_present), .div_ovf(div_ovf),
    .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so), .cr0(cr0)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference behaviour written from the requirements
  task automatic model();
    logic [XLEN-1:0] a, b;
    logic two, c, c32, o, o32, wr;
    a   = invert_a ? ~op_a : op_a;                        // R3
    two = op_b_present | imm_present;                     // R4
    b   = imm_present ? imm : (op_b_present ? op_b : '0);
    c   = (a > result) || (two && b > result);            // R5
    if (is_add) c32 = result[32] ^ a[32] ^ (two ? b[32] : 1'b0);  // R6
    else c32 = (a[31:0] > result[31:0]) || (two && b[31:0] > result[31:0]);
    o   = (a[63] == b[63]) && (result[63] != a[63]);      // R7
    o32 = (a[31] == b[31]) && (result[31] != a[31]);
    if (div_ovf_present) begin o = div_ovf; o32 = div_ovf; end  // R8
    wr  = ovf_en && (div_ovf_present || two);             // R9
    if (in_valid) begin
      if (carry_en && !carry_skip[0]) m_ca = c;            // R11
      if (carry_en && !carry_skip[1]) m_ca32 = c32;
      if (wr) begin m_ov = o; m_ov32 = o32; m_so = m_so | o; end  // R10
      if (record_en)                                      // R12
        m_cr = {result[63], !result[63] && result != 0, result == 0, m_so};
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model();
    #1;
    chk({tag, " flags"}, {ca, ca32, ov, ov32}, {m_ca, m_ca32, m_ov, m_ov32});
    chk({tag, " so/cr0"}, cr0, m_cr);
    chk({tag, " sum"}, {3'b0, so}, {3'b0, m_so});
  endtask

  task automatic setop(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic bp, input logic [XLEN-1:0] r, input logic add);
    in_valid = 1; op_a = a; op_b = b; op_b_present = bp; result = r; is_add = add;
    imm_present = 0; invert_a = 0; carry_skip = 0; div_ovf_present = 0;
    carry_en = 1; ovf_en = 1; record_en = 1;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset", {ca, ca32, ov, ov32}, 4'b0);
    chk("R1 reset cr0", cr0, 4'b0);
    chk("R1 reset so", {3'b0, so}, 4'b0);

    // R5 carry from all-ones wrap; R6 add parity
    setop('1, 64'd1, 1, 64'd0, 1); step("R5");
    chk("R5 literal", {3'b0, ca}, 4'b1);
    setop(64'hFFFF_FFFF, 64'd1, 1, 64'h1_0000_0000, 1); step("R6 add");
    chk("R6 literal", {3'b0, ca32}, 4'b1);
    setop(64'h10, 64'd0, 1, 64'h5, 0); step("R6 non-add");
    // R7 signed overflow at top, none in half
    setop(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 64'h8000_0000_0000_0000, 1); step("R7");
    chk("R7 literal", {2'b0, ov, ov32}, 4'b0010);
    chk("R10 literal", {3'b0, so}, 4'b1);
    // R10: a clean add keeps so
    setop(64'd1, 64'd2, 1, 64'd3, 1); step("R10 sticky");
    chk("R10 kept", {3'b0, so}, 4'b1);
    // R8 divide override
    setop(64'd1, 64'd2, 1, 64'd3, 0); div_ovf_present = 1; div_ovf = 1; step("R8 ovf");
    chk("R8 literal", {2'b0, ov, ov32}, 4'b0011);
    setop(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 64'h8000_0000_0000_0000, 0);
    div_ovf_present = 1; div_ovf = 0; step("R8 clear");
    // R9 single operand: no overflow update
    setop(64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 0, 64'h8000_0000_0000_0000, 0); step("R9");
    chk("R9 literal", {2'b0, ov, ov32}, 4'b0000);
    // R3 inversion
    setop(64'd0, 64'd0, 0, 64'd5, 0); invert_a = 1; step("R3");
    chk("R3 literal", {3'b0, ca}, 4'b1);
    // R4 immediate overrides op_b
    setop(64'd0, 64'd0, 0, 64'd5, 0); imm_present = 1; imm = 64'd9; step("R4");
    chk("R4 literal", {3'b0, ca}, 4'b1);
    // R11 masks
    setop(64'd0, 64'd0, 1, 64'd5, 0); carry_skip = 2'b01; step("R11 mask ca");
    chk("R11 ca held", {3'b0, ca}, 4'b1);
    setop('1, 64'd1, 1, 64'd0, 0); carry_skip = 2'b10; step("R11 mask ca32");
    // R12 zero and negative results
    setop(64'd0, 64'd0, 1, 64'd0, 1); step("R12 zero");
    chk("R12 zero literal", cr0, 4'b0011);
    setop(64'd0, 64'd0, 1, 64'hF000_0000_0000_0000, 1); step("R12 neg");
    // R2 idle strobe and disabled groups
    setop('1, 64'd1, 1, 64'h8000_0000_0000_0000, 0); in_valid = 0; step("R2 idle");
    setop('1, 64'd1, 1, 64'd1, 0); carry_en = 0; ovf_en = 0; record_en = 0; step("R2 enables");

    for (int i = 0; i < 400; i++) begin
      in_valid = ($urandom % 8) != 0;
      op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom}; imm = {$urandom, $urandom};
      result = ($urandom % 6 == 0) ? '0 : {$urandom, $urandom};
      op_b_present = $urandom; imm_present = ($urandom % 4) == 0;
      is_add = $urandom; invert_a = $urandom; carry_en = $urandom; ovf_en = $urandom;
      record_en = $urandom; carry_skip = 2'($urandom);
      div_ovf_present = ($urandom % 5) == 0; div_ovf = $urandom;
      step("R5 R6 R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule